// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block derives an audio master clock and a bit clock from a single fast reference clock. A phase accumulator driven by an 8-bit numerator X and an 8-bit denominator Y produces rate ticks at the reference rate times X/Y. A toggle stage turns those ticks into a square master clock at half that rate. An integer divider then counts master clock periods and produces a bit clock with period equal to the programmed bit divide value plus one.

Every output is a level or a one-cycle enable in the reference clock domain, so downstream logic needs no second clock. A two-bit source select lets the bit divider count a master clock enable supplied from the opposite audio direction instead of the local one. That allows a transmit and a receive path to share one master clock. Any change to X, Y or the bit divide value restarts both dividers from a known phase.

Top module: `afc_clkgen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mclk_en, mclk_out, bclk_en and bclk_out are all 0.
- R2: With X ≤ Y and both nonzero, mclk_en pulses W·X/(2·Y) times (±1) over W reference cycles, and each pulse coincides with a rising edge of mclk_out.
- R3: If X = 0 or Y = 0, mclk_en never pulses and mclk_out stays 0.
- R4: X greater than Y is treated as X = Y, so mclk_en pulses on every second reference cycle.
- R5: bclk_en pulses once for every (B+1) selected master clock pulses, where B is the 8-bit bit divide value.
- R6: Within one bit period, bclk_out is low for floor((B+1)/2) master pulses and then high for the remaining ceil((B+1)/2). With B=0, bclk_out is high after the first pulse.
- R7: With src_sel = 2'b10 the bit divider counts alt_mclk_en pulses and ignores the local master clock. With any other value (00, 01, 11) it counts the local mclk_en and ignores alt_mclk_en.
- R8: On the cycle after any of X, Y or B changes, mclk_out, bclk_out, mclk_en and bclk_en are all 0, and both dividers restart from zero phase.
- R9: mclk_en is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_x | input | 8 | Rate numerator X |
| cfg_y | input | 8 | Rate denominator Y |
| cfg_bdiv | input | 8 | Bit divide value B (divides by B+1) |
| src_sel | input | 2 | Master clock source for the bit divider: 2'b10 = opposite direction, else local |
| alt_mclk_en | input | 1 | Master clock enable from the opposite direction |
| mclk_en | output | 1 | One-cycle pulse per local master clock period |
| mclk_out | output | 1 | Local master clock level |
| bclk_en | output | 1 | One-cycle pulse at the start of each bit period |
| bclk_out | output | 1 | Bit clock level |

## Verification
The rate divider is run with a unity ratio, two non-integer ratios (3/8 and 5/7), a numerator above the denominator, and each operand set to zero. These separate correct accumulation from off-by-one wrap errors, from a missing clamp and from a missing halt. Bit clock timing is checked with even and odd divide values and with a divide of one. A per-period pulse count splits the high and low phases, which shows whether the longer phase falls on the high side. The source select is tried with the local divider halted while opposite-direction pulses arrive, and with those pulses present but not selected. A mid-run change of the divide value confirms the restart.

// File: rtl/afc_pkg.sv
// Package: shared widths and the master clock source encoding for the
// fractional audio clock generator.
package afc_pkg;

    // Source select codes; only SRC_OTHER picks the opposite direction.
    typedef enum logic [1:0] {
        SRC_LOCAL  = 2'b00,
        SRC_RSVD_A = 2'b01,
        SRC_OTHER  = 2'b10,
        SRC_RSVD_B = 2'b11
    } afc_src_e;

endpackage

// File: rtl/afc_cfg_watch.sv
// Module: afc_cfg_watch
// Registers the rate and divide settings, flags any change, and derives the
// clamped numerator and the halt condition used by the rate divider.
// Assumes: settings are quasi-static; a change costs one restart cycle.
module afc_cfg_watch #(
    parameter int RATE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cfg_x,
    input  logic [RATE_W-1:0] cfg_y,
    input  logic [DIV_W-1:0]  cfg_bdiv,
    output logic              chg,
    output logic              halt,
    output logic [RATE_W-1:0] x_eff,
    output logic [RATE_W-1:0] y_q,
    output logic [DIV_W-1:0]  bdiv_q
);

    logic [RATE_W-1:0] x_q;

    // Hold the settings seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            bdiv_q <= '0;
        end else begin
            x_q    <= cfg_x;
            y_q    <= cfg_y;
            bdiv_q <= cfg_bdiv;
        end
    end

    // Detect a setting change and derive the effective rate controls.
    always_comb begin
        chg   = (cfg_x != x_q) || (cfg_y != y_q) || (cfg_bdiv != bdiv_q);
        halt  = (x_q == '0) || (y_q == '0);
        x_eff = (x_q > y_q) ? y_q : x_q;
    end

endmodule

// File: rtl/afc_phase_acc.sv
// Module: afc_phase_acc
// Fractional rate divider: adds the numerator each reference cycle and,
// whenever the sum reaches the denominator, subtracts it and emits a tick.
// Each tick toggles the master clock level; the rising toggle yields the
// master enable pulse. Assumes x_eff <= y_q (clamped upstream).
module afc_phase_acc #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              halt,
    input  logic [RATE_W-1:0] x_eff,
    input  logic [RATE_W-1:0] y_q,
    output logic              mclk_en,
    output logic              mclk_lvl
);

    localparam int SUM_W = RATE_W + 1;

    logic [RATE_W-1:0] acc;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  wrap;
    logic              tick;

    // Next phase and tick decision.
    always_comb begin
        sum  = {1'b0, acc} + {1'b0, x_eff};
        wrap = sum - {1'b0, y_q};
        tick = !halt && (sum >= {1'b0, y_q});
    end

    // Advance the phase, toggle the master level and form the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc      <= '0;
            mclk_lvl <= 1'b0;
            mclk_en  <= 1'b0;
        end else if (halt) begin
            acc      <= '0;
            mclk_en  <= 1'b0;
        end else begin
            acc      <= tick ? wrap[RATE_W-1:0] : sum[RATE_W-1:0];
            mclk_lvl <= mclk_lvl ^ tick;
            mclk_en  <= tick && !mclk_lvl;
        end
    end

endmodule

// File: rtl/afc_src_mux.sv
// Module: afc_src_mux
// Chooses which master enable steps the bit divider. Only the opposite
// direction code routes alt_en; every other code keeps the local enable.
module afc_src_mux
    import afc_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       local_en,
    input  logic       alt_en,
    output logic       step
);

    // Pick the stepping enable.
    always_comb begin
        if (afc_src_e'(src_sel) == SRC_OTHER) step = alt_en;
        else                                  step = local_en;
    end

endmodule

// File: rtl/afc_bit_div.sv
// Module: afc_bit_div
// Integer bit divider: counts 0..div_m1 on each step, emits a period start
// pulse on wrap, and drives the bit clock low for the first floor(N/2)
// counts and high for the rest (N = div_m1 + 1).
module afc_bit_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] div_m1,
    output logic             bclk_en,
    output logic             bclk_lvl
);

    localparam int LOW_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nxt;
    logic             at_end;
    logic [LOW_W-1:0] low_len;

    // Next count and low phase length.
    always_comb begin
        at_end  = (cnt == div_m1);
        cnt_nxt = at_end ? '0 : cnt + 1'b1;
        low_len = ({1'b0, div_m1} + 1'b1) >> 1;
    end

    // Step the counter and update the bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            bclk_en  <= 1'b0;
            bclk_lvl <= 1'b0;
        end else if (step) begin
            cnt      <= cnt_nxt;
            bclk_en  <= at_end;
            bclk_lvl <= ({1'b0, cnt_nxt} >= low_len);
        end else begin
            bclk_en  <= 1'b0;
        end
    end

endmodule

// File: rtl/afc_clkgen.sv
// Module: afc_clkgen (top)
// Fractional audio clock generator: rate divider (ref * X/Y / 2) followed by
// a (B+1) bit divider, with a selectable master source. Single clock domain;
// all outputs are enables or levels in the reference domain.
module afc_clkgen #(
    parameter int RATE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cfg_x,
    input  logic [RATE_W-1:0] cfg_y,
    input  logic [DIV_W-1:0]  cfg_bdiv,
    input  logic [1:0]        src_sel,
    input  logic              alt_mclk_en,
    output logic              mclk_en,
    output logic              mclk_out,
    output logic              bclk_en,
    output logic              bclk_out
);

    logic              cfg_chg;
    logic              halt;
    logic [RATE_W-1:0] x_eff;
    logic [RATE_W-1:0] y_q;
    logic [DIV_W-1:0]  bdiv_q;
    logic              step;

    afc_cfg_watch #(.RATE_W(RATE_W), .DIV_W(DIV_W)) i_watch (
        .clk(clk), .rst_n(rst_n), .cfg_x(cfg_x), .cfg_y(cfg_y),
        .cfg_bdiv(cfg_bdiv), .chg(cfg_chg), .halt(halt), .x_eff(x_eff),
        .y_q(y_q), .bdiv_q(bdiv_q)
    );

    afc_phase_acc #(.RATE_W(RATE_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .halt(halt),
        .x_eff(x_eff), .y_q(y_q), .mclk_en(mclk_en), .mclk_lvl(mclk_out)
    );

    afc_src_mux i_mux (
        .src_sel(src_sel), .local_en(mclk_en), .alt_en(alt_mclk_en),
        .step(step)
    );

    afc_bit_div #(.DIV_W(DIV_W)) i_bdiv (
        .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .step(step),
        .div_m1(bdiv_q), .bclk_en(bclk_en), .bclk_lvl(bclk_out)
    );

endmodule

// File: rtl/afc_clkgen_chk.sv
// Module: afc_clkgen_chk
// Property checker for afc_clkgen, attached by bind below.
module afc_clkgen_chk #(
    parameter int RATE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] cfg_x,
    input logic [RATE_W-1:0] cfg_y,
    input logic [1:0]        src_sel,
    input logic              alt_mclk_en,
    input logic              mclk_en,
    input logic              mclk_out,
    input logic              bclk_en,
    input logic              bclk_out,
    input logic              cfg_chg
);

    logic sel_en;

    // Enable the bit divider is expected to follow.
    always_comb sel_en = (src_sel == 2'b10) ? alt_mclk_en : mclk_en;

    a_r2_en_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> $rose(mclk_out));

    a_r3_x_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_x == '0) |=> !mclk_en);

    a_r3_y_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_y == '0) |=> !mclk_en);

    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |=> !mclk_en);

    a_r5_bclk_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |-> $past(sel_en));

    a_r6_bclk_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sel_en) && !$past(cfg_chg)) |-> $stable(bclk_out));

    a_r8_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!mclk_out && !bclk_out && !mclk_en && !bclk_en));

endmodule

bind afc_clkgen afc_clkgen_chk #(.RATE_W(RATE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .src_sel(src_sel), .alt_mclk_en(alt_mclk_en), .mclk_en(mclk_en),
    .mclk_out(mclk_out), .bclk_en(bclk_en), .bclk_out(bclk_out),
    .cfg_chg(cfg_chg)
);

// File: tb/test_afc_clkgen.sv
module test_afc_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_x = '0;
    logic [7:0] cfg_y = '0;
    logic [7:0] cfg_bdiv = '0;
    logic [1:0] src_sel = 2'b00;
    logic       alt_mclk_en = 1'b0;
    logic       mclk_en, mclk_out, bclk_en, bclk_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string tag;
        int    em, tm, eb, tb;
    } exp_t;
    exp_t sb_q[$];

    bit win_active = 0;
    bit win_done   = 0;
    bit alt_on     = 0;
    bit done       = 0;

    afc_clkgen i_afc_clkgen (
        .clk(clk), .rst_n(rst_n), .cfg_x(cfg_x), .cfg_y(cfg_y),
        .cfg_bdiv(cfg_bdiv), .src_sel(src_sel), .alt_mclk_en(alt_mclk_en),
        .mclk_en(mclk_en), .mclk_out(mclk_out), .bclk_en(bclk_en),
        .bclk_out(bclk_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Opposite-direction master pulses: one every three cycles when enabled.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            alt_mclk_en = alt_on && (ph == 0);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    // Monitor: counts over a window, then pops and compares the expectation.
    initial begin
        int nm = 0, nb = 0, rises = 0, misalign = 0, b2b = 0, hi_mclk = 0;
        bit pm = 0, po = 0;
        forever begin
            @(negedge clk);
            if (win_active) begin
                if (mclk_en) nm++;
                if (bclk_en) nb++;
                if (mclk_out && !po) rises++;
                if (mclk_en && !mclk_out) misalign++;
                if (mclk_en && pm) b2b++;
                if (mclk_out) hi_mclk++;
            end else begin
                nm = 0; nb = 0; rises = 0; misalign = 0; b2b = 0; hi_mclk = 0;
            end
            pm = mclk_en; po = mclk_out;
            if (win_done) begin
                exp_t e = sb_q.pop_front();
                int dm = nm - e.em;
                int db = nb - e.eb;
                chk((dm <= e.tm) && (dm >= -e.tm), e.tag, "mclk_en count", nm, e.em);
                chk((db <= e.tb) && (db >= -e.tb), e.tag, "bclk_en count", nb, e.eb);
                chk(misalign == 0 && rises >= nm - 1 && rises <= nm + 1,
                    "R2", "mclk_en pulses without mclk_out rise", misalign, 0);
                chk(b2b == 0, "R9", "back-to-back mclk_en", b2b, 0);
                if (e.em == 0 && e.tm == 0)
                    chk(hi_mclk == 0, "R3", "mclk_out high cycles while halted", hi_mclk, 0);
                win_done = 0;
            end
        end
    end

    // Driver: apply settings, push the expectation, run a window.
    task automatic run_case(input string tag, input int x, input int y,
                            input int b, input logic [1:0] src, input bit alt,
                            input int w);
        exp_t e;
        int xe, n, em, alt_p;
        @(posedge clk); #1;
        cfg_x = 8'(x); cfg_y = 8'(y); cfg_bdiv = 8'(b); src_sel = src; alt_on = alt;
        repeat (3) @(posedge clk);
        #1;
        xe = (x > y) ? y : x;
        n  = b + 1;
        em = (x == 0 || y == 0) ? 0 : (w * xe) / (2 * y);
        alt_p = alt ? w / 3 : 0;
        e.tag = tag;
        e.em  = em;
        e.tm  = (em == 0) ? 0 : 1;
        e.eb  = ((src == 2'b10) ? alt_p : em) / n;
        e.tb  = (e.eb == 0 && ((src == 2'b10) ? alt_p : em) == 0) ? 0 : 2;
        sb_q.push_back(e);
        win_active = 1;
        repeat (w) @(posedge clk);
        #1;
        win_active = 0;
        win_done = 1;
        wait (!win_done);
    endtask

    // Count master pulses in the low and high parts of one bit period.
    task automatic duty(input int b, input int x, input int y);
        int lo = 0, hi = 0, n = b + 1;
        @(posedge clk); #1;
        cfg_x = 8'(x); cfg_y = 8'(y); cfg_bdiv = 8'(b); src_sel = 2'b00; alt_on = 0;
        do @(negedge clk); while (!bclk_en);
        forever begin
            @(negedge clk);
            if (bclk_en) break;
            if (mclk_en) begin
                if (bclk_out) hi++; else lo++;
            end
        end
        // R6: pulse counted with the level that applied before it stepped
        chk(lo == n / 2, "R6", "low phase master pulses", lo, n / 2);
        chk(hi == n - n / 2, "R6", "high phase master pulses", hi, n - n / 2);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog run did not complete act=0 exp=1");
        finish_run();
    end

    initial begin
        cfg_x = 8'd1; cfg_y = 8'd1; cfg_bdiv = 8'd1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        chk({mclk_en, mclk_out, bclk_en, bclk_out} == 4'b0, "R1",
            "outputs in reset", {mclk_en, mclk_out, bclk_en, bclk_out}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk({mclk_en, mclk_out, bclk_en, bclk_out} == 4'b0, "R1",
            "outputs first cycle after reset", {mclk_en, mclk_out, bclk_en, bclk_out}, 0);

        run_case("R2", 1, 1, 1, 2'b00, 0, 400);
        run_case("R2", 3, 8, 3, 2'b00, 0, 1600);
        run_case("R5", 5, 7, 2, 2'b00, 0, 1400);
        run_case("R4", 200, 50, 0, 2'b00, 0, 600);
        run_case("R3", 0, 9, 1, 2'b00, 0, 500);
        run_case("R3", 9, 0, 1, 2'b00, 0, 500);
        run_case("R7", 0, 4, 1, 2'b10, 1, 1200);
        run_case("R7", 0, 4, 1, 2'b00, 1, 600);
        run_case("R7", 1, 2, 0, 2'b11, 1, 800);
        run_case("R7", 1, 2, 3, 2'b01, 0, 800);

        duty(3, 1, 1);
        duty(2, 1, 1);
        duty(4, 2, 3);
        duty(0, 1, 1);

        // R8: change the divide value mid-run, outputs clear the next cycle
        @(posedge clk); #1;
        cfg_x = 8'd1; cfg_y = 8'd1; cfg_bdiv = 8'd5; src_sel = 2'b00;
        repeat (40) @(posedge clk);
        #1;
        cfg_bdiv = 8'd6;
        @(posedge clk);
        @(negedge clk);
        chk({mclk_en, mclk_out, bclk_en, bclk_out} == 4'b0, "R8",
            "outputs after setting change", {mclk_en, mclk_out, bclk_en, bclk_out}, 0);
        // R8: restart from zero phase: first bclk_en after 7 master pulses
        begin
            int cnt = 0;
            forever begin
                @(negedge clk);
                if (bclk_en) break;
                if (mclk_en) cnt++;
            end
            chk(cnt == 7, "R8", "master pulses to first bit period end", cnt, 7);
        end

        finish_run();
    end

endmodule